// File: doc/BRIEF.md
# Dual-Rate Compressor Gain Controller

This block holds the gain code of a programmable-gain input stage that limits loud signals. Two comparator flags come in from the analog side: one says the amplifier output is above the upper threshold, the other says it is below a lower threshold set 3 dB further down. From these flags the block steps a 7-bit gain code up or down in 0.5 dB units. The code runs from 0x00 (-1 dB) to 0x52 (+40 dB).

Each step is paced by an exponential rate code, and gain increases are held back until a quiet period has passed. In the dual-rate mode a fast tracker reacts to bursts. A slow tracker follows the fast one at its own, slower rates, and the applied gain is the lower of the two. Short peaks therefore recover quickly, while the long-term level moves slowly. Two fixed modes ignore the flags and move the gain to the programmed code, either in steps or at once. A read port returns either the stored gain setting or the live gain.

Top module: `cgc_gain_ctrl`

## Requirements
- R1: After reset both trackers hold 0x46, so `gain_now` reads 0x46.
- R2: A rate code c (4 bits) issues one 0.5 dB step every 8·2^(15−c) clock cycles. In each 8-bit rate byte, bits [7:4] are the attack (decrease) code and bits [3:0] are the release (increase) code.
- R3: In the automatic modes (`cmp_mode` 00 and 01), the fast tracker falls one step per fast-attack period while `over_thr` is high. It never goes below 0x00, and no increase happens while `over_thr` is high.
- R4: In the automatic modes, an increase is allowed only after `under_thr` has been high, with `over_thr` low, for HOLD_LONG cycles when `hold_short`=0 or HOLD_SHORT cycles when `hold_short`=1. The first step follows one release period after that.
- R5: After the hold time, the fast tracker rises one step per fast-release period and stops at the target `gain_cfg[6:0]`. A tracker above the target falls to it at the attack rate.
- R6: When both flags are low, the trackers keep their values and the quiet-time count restarts from zero.
- R7: In dual-rate mode (00), the slow tracker moves one step toward the fast tracker per slow-attack period (when above it) or slow-release period (when below it). `gain_now` is the smaller of the two trackers.
- R8: In single-rate mode (01), `gain_now` equals the fast tracker, and the slow tracker is loaded with the fast value every cycle.
- R9: In fixed stepping mode (10), the gain moves to the target through every intermediate code, at the fast-attack rate going down and the fast-release rate going up, regardless of the flags.
- R10: In fixed immediate mode (11), the gain equals the target one clock after the target is applied.
- R11: A target above 0x52 is treated as 0x52.
- R12: With `gain_cfg[7]`=0, `gain_rd` returns `gain_cfg` unchanged. With `gain_cfg[7]`=1, it returns {1, `gain_now`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.28 MHz timing base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| over_thr | input | 1 | Amplifier output above the upper threshold |
| under_thr | input | 1 | Amplifier output below the lower threshold |
| cmp_mode | input | 2 | 00 dual-rate, 01 single-rate, 10 fixed stepping, 11 fixed immediate |
| hold_short | input | 1 | Selects the short quiet time before gain increases |
| fast_rate_cfg | input | 8 | Fast attack code [7:4], fast release code [3:0] |
| slow_rate_cfg | input | 8 | Slow attack code [7:4], slow release code [3:0] |
| gain_cfg | input | 8 | Bit 7 read mode, bits [6:0] target or maximum gain |
| gain_now | output | 7 | Applied gain code, 0.5 dB per count |
| gain_rd | output | 8 | Readback value selected by `gain_cfg[7]` |

## Verification
A pacer that counts wrong shows up at `gain_now` as a step landing early or late. The bench samples step counts midway between expected step edges, so a one-period error is seen within one rate period. A quiet-time counter that fails to restart, or expires at the wrong limit, produces a gain increase a whole hold window too soon, and this is checked before the window closes. A slow tracker that stalls or overruns changes the minimum in dual-rate mode, so `gain_now` differs from the expected value after one slow period.

// File: rtl/cgc_pkg.sv
// Package: shared gain-code type, limits and mode encoding for the
// compressor gain controller. Assumes 0.5 dB per gain count.
package cgc_pkg;
    localparam int GAIN_W = 7;
    typedef logic [GAIN_W-1:0] gain_t;

    // Highest legal gain code (+40 dB) and the value after reset (+34 dB).
    localparam gain_t GAIN_TOP = 7'd82;
    localparam gain_t GAIN_RST = 7'd70;

    typedef enum logic [1:0] {
        MODE_DUAL     = 2'b00,
        MODE_SINGLE   = 2'b01,
        MODE_FIX_STEP = 2'b10,
        MODE_FIX_IMM  = 2'b11
    } cgc_mode_e;
endpackage

// File: rtl/cgc_step_pacer.sv
// Step pacer: while run is high, pulses tick once every
// BASE_CYC << (2**CODE_W-1 - code) cycles. Dropping run restarts the period.
// Assumes BASE_CYC >= 2 so two ticks are never adjacent.
module cgc_step_pacer #(
    parameter int BASE_CYC = 8,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam int CNT_W    = $clog2(BASE_CYC) + MAX_CODE + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic [CODE_W-1:0] shift_amt;

    // Period length doubles for each step down in rate code.
    always_comb begin
        shift_amt = CODE_W'(MAX_CODE) - code;
        period    = CNT_W'(BASE_CYC) << shift_amt;
    end

    assign tick = run && (cnt >= period - CNT_W'(1));

    // Cycle counter within the current step period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R2: a step period is at least two cycles, so ticks never touch.
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cgc_hold_timer.sv
// Quiet-time timer: counts cycles while count_en is high and raises done
// once the selected limit is reached; count_en low clears it at once.
// Assumes LONG_CYC >= SHORT_CYC >= 1.
module cgc_hold_timer #(
    parameter int LONG_CYC  = 64000,
    parameter int SHORT_CYC = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic short_sel,
    output logic done
);
    localparam int HOLD_W = $clog2(LONG_CYC + 1);

    logic [HOLD_W-1:0] cnt;
    logic [HOLD_W-1:0] limit;

    assign limit = short_sel ? HOLD_W'(SHORT_CYC) : HOLD_W'(LONG_CYC);
    assign done  = cnt >= limit;

    // Saturating quiet-time count, cleared whenever the quiet condition breaks.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + HOLD_W'(1);
        end
    end

    // R6: a broken quiet period leaves the timer not expired.
    a_r6_quiet_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(count_en)) |-> !done);
endmodule

// File: rtl/cgc_level.sv
// Gain tracker: a saturating up/down counter of gain codes with a parallel
// load. A down step wins over an up step; load wins over both.
module cgc_level
    import cgc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  gain_t load_val,
    input  logic  dn_step,
    input  logic  up_step,
    output gain_t level
);
    // Tracker update: load, then one step down or up within the legal range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= GAIN_RST;
        end else if (load) begin
            level <= load_val;
        end else if (dn_step && level != '0) begin
            level <= level - gain_t'(1);
        end else if (up_step && level < GAIN_TOP) begin
            level <= level + gain_t'(1);
        end
    end

    // R9: without a load the tracker moves by at most one code per cycle.
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |->
        ((level == $past(level)) || (level == $past(level) + gain_t'(1)) ||
         (level + gain_t'(1) == $past(level))));

    // R11: the tracker never leaves the legal code range.
    a_r11_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        level <= GAIN_TOP);
endmodule

// File: rtl/cgc_gain_ctrl.sv
// Compressor gain controller top: decides step direction for a fast and a
// slow tracker from the threshold flags and mode, paces each direction with
// its own rate code, and applies the lower tracker in dual-rate mode.
// Assumes the flags are already synchronous to clk.
module cgc_gain_ctrl
    import cgc_pkg::*;
#(
    parameter int BASE_CYC   = 8,
    parameter int RATE_W     = 4,
    parameter int HOLD_LONG  = 64000,
    parameter int HOLD_SHORT = 32000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                over_thr,
    input  logic                under_thr,
    input  logic [1:0]          cmp_mode,
    input  logic                hold_short,
    input  logic [2*RATE_W-1:0] fast_rate_cfg,
    input  logic [2*RATE_W-1:0] slow_rate_cfg,
    input  logic [GAIN_W:0]     gain_cfg,
    output logic [GAIN_W-1:0]   gain_now,
    output logic [GAIN_W:0]     gain_rd
);
    localparam int N_PACE = 4;
    localparam int P_FDN  = 0;
    localparam int P_FUP  = 1;
    localparam int P_SDN  = 2;
    localparam int P_SUP  = 3;

    cgc_mode_e mode;
    logic      auto_mode;
    gain_t     target;
    gain_t     fast_lvl;
    gain_t     slow_lvl;
    logic      quiet_done;
    logic      quiet_en;
    logic      fast_load;
    logic      slow_load;

    logic [N_PACE-1:0][RATE_W-1:0] pace_code;
    logic [N_PACE-1:0]             pace_run;
    logic [N_PACE-1:0]             pace_tick;

    assign mode      = cgc_mode_e'(cmp_mode);
    assign auto_mode = (mode == MODE_DUAL) || (mode == MODE_SINGLE);

    // Target code, limited to the top of the legal range.
    always_comb begin
        if (gain_cfg[GAIN_W-1:0] > GAIN_TOP) begin
            target = GAIN_TOP;
        end else begin
            target = gain_cfg[GAIN_W-1:0];
        end
    end

    // Quiet time counts only while the output is low and not also high.
    assign quiet_en = auto_mode && under_thr && !over_thr;

    cgc_hold_timer #(
        .LONG_CYC (HOLD_LONG),
        .SHORT_CYC(HOLD_SHORT)
    ) u_quiet (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (quiet_en),
        .short_sel(hold_short),
        .done     (quiet_done)
    );

    // Rate code for each pacer: attack in the upper nibble, release lower.
    always_comb begin
        pace_code[P_FDN] = fast_rate_cfg[2*RATE_W-1:RATE_W];
        pace_code[P_FUP] = fast_rate_cfg[RATE_W-1:0];
        pace_code[P_SDN] = slow_rate_cfg[2*RATE_W-1:RATE_W];
        pace_code[P_SUP] = slow_rate_cfg[RATE_W-1:0];
    end

    // Fast tracker direction: flags in automatic modes, target in fixed ones.
    always_comb begin
        pace_run[P_FDN] = 1'b0;
        pace_run[P_FUP] = 1'b0;
        fast_load       = 1'b0;
        unique case (mode)
            MODE_DUAL, MODE_SINGLE: begin
                pace_run[P_FDN] = over_thr || (fast_lvl > target);
                pace_run[P_FUP] = !over_thr && under_thr && quiet_done &&
                                  (fast_lvl < target);
            end
            MODE_FIX_STEP: begin
                pace_run[P_FDN] = fast_lvl > target;
                pace_run[P_FUP] = fast_lvl < target;
            end
            MODE_FIX_IMM: begin
                fast_load = 1'b1;
            end
            default: begin
                fast_load = 1'b0;
            end
        endcase
    end

    // Slow tracker direction: chase the fast tracker in dual mode only.
    always_comb begin
        slow_load       = (mode != MODE_DUAL);
        pace_run[P_SDN] = (mode == MODE_DUAL) && (slow_lvl > fast_lvl);
        pace_run[P_SUP] = (mode == MODE_DUAL) && (slow_lvl < fast_lvl);
    end

    for (genvar i = 0; i < N_PACE; i++) begin : g_pacer
        cgc_step_pacer #(
            .BASE_CYC(BASE_CYC),
            .CODE_W  (RATE_W)
        ) u_pacer (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (pace_run[i]),
            .code (pace_code[i]),
            .tick (pace_tick[i])
        );
    end

    cgc_level u_fast (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fast_load),
        .load_val(target),
        .dn_step (pace_tick[P_FDN]),
        .up_step (pace_tick[P_FUP]),
        .level   (fast_lvl)
    );

    cgc_level u_slow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (slow_load),
        .load_val(fast_lvl),
        .dn_step (pace_tick[P_SDN]),
        .up_step (pace_tick[P_SUP]),
        .level   (slow_lvl)
    );

    // Applied gain: lower tracker in dual mode, fast tracker otherwise.
    always_comb begin
        if (mode == MODE_DUAL && slow_lvl < fast_lvl) begin
            gain_now = slow_lvl;
        end else begin
            gain_now = fast_lvl;
        end
    end

    // Readback: stored setting, or live gain when the read-mode bit is set.
    always_comb begin
        if (gain_cfg[GAIN_W]) begin
            gain_rd = {1'b1, gain_now};
        end else begin
            gain_rd = gain_cfg;
        end
    end

    // R3: in single-rate mode an over-threshold cycle never raises the gain.
    a_r3_attack_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode == MODE_SINGLE && $past(mode) == MODE_SINGLE &&
         $past(over_thr)) |-> (gain_now <= $past(gain_now)));

    // R4: in single-rate mode no rise happens before the quiet time expires.
    a_r4_hold_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode == MODE_SINGLE && $past(mode) == MODE_SINGLE &&
         !$past(quiet_done)) |-> (gain_now <= $past(gain_now)));

    // R10: fixed immediate mode shows the previous cycle's target.
    a_r10_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode == MODE_FIX_IMM && $past(mode) == MODE_FIX_IMM)
        |-> (gain_now == $past(target)));

    // R11: the applied gain stays inside the legal code range.
    a_r11_gain_range: assert property (@(posedge clk) disable iff (!rst_n)
        gain_now <= GAIN_TOP);

    // R7: in dual mode the applied gain never exceeds the slow tracker.
    a_r7_dual_min: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DUAL) |-> (gain_now <= slow_lvl && gain_now <= fast_lvl));
endmodule

// File: tb/cgc_gain_ctrl_bench.sv
// Directed bench for the compressor gain controller. Inputs change and
// outputs are sampled on the falling clock edge.
module cgc_gain_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       over_thr = 1'b0;
    logic       under_thr = 1'b0;
    logic [1:0] cmp_mode = 2'b01;
    logic       hold_short = 1'b0;
    logic [7:0] fast_rate_cfg = 8'hFE;
    logic [7:0] slow_rate_cfg = 8'hDC;
    logic [7:0] gain_cfg = 8'h46;
    logic [6:0] gain_now;
    logic [7:0] gain_rd;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cgc_gain_ctrl #(
        .BASE_CYC  (8),
        .RATE_W    (4),
        .HOLD_LONG (64),
        .HOLD_SHORT(32)
    ) u_cgc_gain_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .over_thr     (over_thr),
        .under_thr    (under_thr),
        .cmp_mode     (cmp_mode),
        .hold_short   (hold_short),
        .fast_rate_cfg(fast_rate_cfg),
        .slow_rate_cfg(slow_rate_cfg),
        .gain_cfg     (gain_cfg),
        .gain_now     (gain_now),
        .gain_rd      (gain_rd)
    );

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: reset value on both outputs.
    task automatic t_reset;
        rst_n = 1'b0;
        wait_neg(4);
        rst_n = 1'b1;
        wait_neg(1);
        check("R1 gain after reset", {1'b0, gain_now}, 8'h46);
        check("R12 stored readback", gain_rd, 8'h46);
    endtask

    // R3, R6: attack in single-rate mode, then both flags low holds.
    task automatic t_attack;
        over_thr = 1'b1;
        wait_neg(68);
        check("R3 eight attack steps", {1'b0, gain_now}, 8'h3E);
        over_thr = 1'b0;
        wait_neg(20);
        check("R6 idle holds gain", {1'b0, gain_now}, 8'h3E);
    endtask

    // R4, R5: long quiet time, release pace, stop at target.
    task automatic t_release_long;
        under_thr = 1'b1;
        wait_neg(60);
        check("R4 no rise inside long hold", {1'b0, gain_now}, 8'h3E);
        wait_neg(60);
        check("R5 three release steps", {1'b0, gain_now}, 8'h41);
        wait_neg(200);
        check("R5 release stops at target", {1'b0, gain_now}, 8'h46);
        under_thr = 1'b0;
    endtask

    // R6: a gap with both flags low restarts the quiet time.
    task automatic t_quiet_restart;
        over_thr = 1'b1;
        wait_neg(36);
        over_thr = 1'b0;
        check("R3 four attack steps", {1'b0, gain_now}, 8'h42);
        under_thr = 1'b1;
        wait_neg(50);
        under_thr = 1'b0;
        wait_neg(5);
        under_thr = 1'b1;
        wait_neg(50);
        check("R6 quiet time restarted", {1'b0, gain_now}, 8'h42);
        wait_neg(38);
        check("R6 rise after full hold", {1'b0, gain_now}, 8'h43);
        under_thr = 1'b0;
    endtask

    // R4: short quiet time selection.
    task automatic t_release_short;
        hold_short = 1'b1;
        over_thr = 1'b1;
        wait_neg(28);
        over_thr = 1'b0;
        check("R3 three attack steps", {1'b0, gain_now}, 8'h40);
        under_thr = 1'b1;
        wait_neg(56);
        check("R4 short hold rise", {1'b0, gain_now}, 8'h41);
        wait_neg(200);
        check("R5 back at target", {1'b0, gain_now}, 8'h46);
        under_thr = 1'b0;
    endtask

    // R7, R12: dual-rate minimum and live readback.
    task automatic t_dual;
        cmp_mode = 2'b00;
        over_thr = 1'b1;
        wait_neg(68);
        check("R7 fast tracker governs attack", {1'b0, gain_now}, 8'h3E);
        over_thr = 1'b0;
        wait_neg(300);
        check("R7 slow tracker settled", {1'b0, gain_now}, 8'h3E);
        under_thr = 1'b1;
        wait_neg(200);
        check("R7 slow tracker limits recovery", {1'b0, gain_now}, 8'h40);
        gain_cfg = 8'hC6;
        #1;
        check("R12 live readback", gain_rd, 8'hC0);
        gain_cfg = 8'h46;
        #1;
        check("R12 stored readback", gain_rd, 8'h46);
        under_thr = 1'b0;
    endtask

    // R8, R9: fixed stepping both ways.
    task automatic t_fixed_step;
        cmp_mode = 2'b10;
        gain_cfg = 8'h30;
        #1;
        check("R8 fast tracker applied outside dual", {1'b0, gain_now}, 8'h46);
        wait_neg(44);
        check("R9 five down steps", {1'b0, gain_now}, 8'h41);
        wait_neg(200);
        check("R9 reached lower target", {1'b0, gain_now}, 8'h30);
        gain_cfg = 8'h34;
        wait_neg(40);
        check("R9 two up steps", {1'b0, gain_now}, 8'h32);
        wait_neg(100);
        check("R9 reached upper target", {1'b0, gain_now}, 8'h34);
    endtask

    // R10, R11, R12: immediate mode, target limit, stored readback.
    task automatic t_fixed_imm;
        cmp_mode = 2'b11;
        gain_cfg = 8'h10;
        wait_neg(1);
        check("R10 immediate load", {1'b0, gain_now}, 8'h10);
        gain_cfg = 8'h7F;
        wait_neg(1);
        check("R11 target limited", {1'b0, gain_now}, 8'h52);
        check("R12 raw setting read", gain_rd, 8'h7F);
    endtask

    // R3: attack floor at code zero.
    task automatic t_floor;
        gain_cfg = 8'h02;
        wait_neg(1);
        cmp_mode = 2'b01;
        over_thr = 1'b1;
        wait_neg(60);
        check("R3 floor at zero", {1'b0, gain_now}, 8'h00);
        over_thr = 1'b0;
    endtask

    // R2, R5: slower attack code and lowered target in automatic mode.
    task automatic t_rate_code;
        cmp_mode = 2'b11;
        gain_cfg = 8'h46;
        wait_neg(1);
        cmp_mode = 2'b01;
        fast_rate_cfg = 8'hDE;
        over_thr = 1'b1;
        wait_neg(100);
        check("R2 code 13 attack pace", {1'b0, gain_now}, 8'h43);
        over_thr = 1'b0;
        gain_cfg = 8'h40;
        wait_neg(100);
        check("R5 lowered target pulls gain down", {1'b0, gain_now}, 8'h40);
    endtask

    initial begin
        wait_neg(1);
        t_reset();
        t_attack();
        t_release_long();
        t_quiet_restart();
        t_release_short();
        t_dual();
        t_fixed_step();
        t_fixed_imm();
        t_floor();
        t_rate_code();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule